// File: doc/BRIEF.md
# Paged Serial EEPROM Command Controller

This block is the memory command layer that sits behind a two-wire slave engine in a 256 x 8 serial EEPROM. The slave engine decodes the bus. It reports Start, Stop and a matched device-address header with its direction bit, and it moves bytes in both directions. This controller interprets those bytes. It keeps the 8-bit internal address pointer and gathers write data in a 16-byte page buffer. On Stop it commits that buffer to the array as one timed programming cycle. It also serves current-address, random and sequential reads from a synchronous register array.

In a write transaction, the first byte after the header loads the pointer. Every later byte goes into the page buffer at the pointer's low four bits, and only those four bits advance. When Stop closes a write that carried data, and write protect is low, the busy flag rises for a parameterised number of clocks. During that window the buffered bytes are written into the array, and the slave engine must stay silent. A repeated Start simply drops any buffered data. This makes random reads possible: a dummy write sets the pointer, then a read header follows. Reads advance the full 8-bit pointer and roll over from the top of the array to the bottom.

Both byte streams use valid/ready. Incoming write bytes are offered on `wdat_valid`. A byte transfers only in a cycle where `wdat_ready` is also high. `wdat_ready` is high only while a write transaction is open and the block is not busy, so the slave engine must hold a byte until it is taken. Read bytes are offered on `rdat_valid` with `rdat_data`. Both stay fixed until `rdat_ready` takes the byte, and each transfer advances the pointer. Start, Stop, header, write protect and busy are plain level or pulse signals.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, busy, wdat_ready and rdat_valid are low and the address pointer is 0. A read header with no address phase then returns the byte at array location 0. Reset does not clear the array.
- R2: After a write header (hdr_read=0), the first accepted byte loads the pointer. Each later accepted byte is data for the location the pointer selects.
- R3: After each data byte, only pointer bits [3:0] increment. Bits [7:4] stay fixed, so data continues at the first byte of the same page after its last byte.
- R4: If more than 16 data bytes arrive before Stop, a later byte replaces the earlier buffered byte at the same wrapped position. The array receives the last value for each position.
- R5: A Stop that closes a write with at least one data byte starts programming. Busy rises in the cycle after the Stop pulse. Only the locations that received data change.
- R6: A read with no address phase returns the byte at the pointer, which is one past the last location read. After the byte at 255 it continues from 0.
- R7: Each transferred read byte advances the full 8-bit pointer, so a sequential read runs 0xFE, 0xFF, 0x00, 0x01.
- R8: If wp is high in the Stop cycle of a write, no array location changes and busy stays low.
- R9: A Start pulse during a write discards the buffered data. No programming starts, so a dummy write followed by a read header returns the byte at the loaded address.
- R10: Busy stays high for exactly PROG_CYCLES clocks and then clears by itself. While busy, headers are ignored, wdat_ready is low and rdat_valid is low.
- R11: A write that reaches Stop with no data byte after the address byte starts no programming, and busy stays low.
- R12: After a completed write, the pointer is one past the last byte written, wrapped within its page. A following read with no address phase returns that location.
- R13: While rdat_valid is high and rdat_ready is low, rdat_valid and rdat_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | One-cycle pulse: Start or repeated Start seen |
| bus_stop | input | 1 | One-cycle pulse: Stop seen |
| hdr_valid | input | 1 | One-cycle pulse: device-address header matched |
| hdr_read | input | 1 | Direction of the header, 1 = read |
| wp | input | 1 | Write protect, sampled in the Stop cycle |
| wdat_valid | input | 1 | Write byte offered by the slave engine |
| wdat_ready | output | 1 | Controller accepts a write byte |
| wdat_data | input | 8 | Write byte |
| rdat_valid | output | 1 | Read byte available |
| rdat_ready | input | 1 | Slave engine takes the read byte |
| rdat_data | output | 8 | Read byte |
| busy | output | 1 | Programming cycle in progress |

## Verification
The write path is tried with six write patterns, each followed by a readback of the whole page. A single byte shows that the address phase and data phase are kept apart. A partial run shows that untouched bytes survive. A run that crosses the end of a page shows the four-bit wrap rather than a carry into the next page. A run of twenty bytes shows that later bytes win at the wrapped slots. A protected write shows that nothing changes, and a full page shows the complete commit. Directed reads separate the in-page wrap used by writes from the whole-array wrap used by reads. They also show a dummy write without data apart from one with data, where the repeated Start must still block the commit.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WR_ADDR  = 3'd1,
    ST_WR_DATA  = 3'd2,
    ST_RD_FETCH = 3'd3,
    ST_RD_SEND  = 3'd4
  } ctl_state_e;

endpackage

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata_q <= cells[raddr];
  end
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              any_hit
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic              hit_q  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
        hit_q[g]  <= 1'b0;
      end else if (clr) begin
        hit_q[g]  <= 1'b0;
      end else if (wr_en && (wr_idx == PAGE_W'(g))) begin
        slot_q[g] <= wr_data;
        hit_q[g]  <= 1'b1;
      end
    end
  end

  always_comb begin
    any_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) any_hit = any_hit | hit_q[i];
  end

  assign rd_data = slot_q[rd_idx];
  assign rd_hit  = hit_q[rd_idx];
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  output logic                              busy,
  output logic [$clog2(PROG_CYCLES+1)-1:0]  elapsed
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign elapsed = cnt_q;
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              hdr_valid,
  input  logic              hdr_read,
  input  logic              wp,
  input  logic              wdat_valid,
  output logic              wdat_ready,
  input  logic [DATA_W-1:0] wdat_data,
  output logic              rdat_valid,
  input  logic              rdat_ready,
  output logic [DATA_W-1:0] rdat_data,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q;
  logic [ROW_W-1:0]  row_q;

  logic              wr_fire, rd_fire, hdr_take, commit_go;
  logic              in_data_phase;
  logic              buf_any, buf_hit;
  logic [DATA_W-1:0] buf_byte;
  logic [CNT_W-1:0]  prog_elapsed;
  logic              commit_active;
  logic [PAGE_W-1:0] commit_idx;
  logic              arr_we;
  logic [DATA_W-1:0] arr_q;

  // handshake decode
  assign wr_fire       = wdat_valid && wdat_ready;
  assign rd_fire       = rdat_valid && rdat_ready;
  assign hdr_take      = hdr_valid && !busy;
  assign in_data_phase = (state_q == ST_WR_DATA);
  assign commit_go     = bus_stop && in_data_phase && buf_any && !wp;

  assign wdat_ready = ((state_q == ST_WR_ADDR) || in_data_phase) && !busy;
  assign rdat_valid = (state_q == ST_RD_SEND);
  assign rdat_data  = arr_q;

  // transaction sequencing
  always_comb begin
    state_d = state_q;
    if (bus_start || bus_stop) begin
      state_d = ST_IDLE;
    end else if (hdr_take) begin
      state_d = hdr_read ? ST_RD_FETCH : ST_WR_ADDR;
    end else begin
      unique case (state_q)
        ST_WR_ADDR:  if (wr_fire) state_d = ST_WR_DATA;
        ST_RD_FETCH: state_d = ST_RD_SEND;
        ST_RD_SEND:  if (rd_fire) state_d = ST_RD_FETCH;
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // address pointer and committed page row
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      row_q <= '0;
    end else if (wr_fire && (state_q == ST_WR_ADDR)) begin
      ptr_q <= wdat_data[ADDR_W-1:0];
    end else if (wr_fire && in_data_phase) begin
      ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
      row_q             <= ptr_q[ADDR_W-1:PAGE_W];
    end else if (rd_fire) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  eeprom_page_buf #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hdr_take && !hdr_read),
    .wr_en   (wr_fire && in_data_phase),
    .wr_idx  (ptr_q[PAGE_W-1:0]),
    .wr_data (wdat_data),
    .rd_idx  (commit_idx),
    .rd_data (buf_byte),
    .rd_hit  (buf_hit),
    .any_hit (buf_any)
  );

  eeprom_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (commit_go),
    .busy    (busy),
    .elapsed (prog_elapsed)
  );

  // one buffered slot is moved into the array per clock at the start of the window
  assign commit_active = busy && (prog_elapsed < CNT_W'(PAGE_BYTES));
  assign commit_idx    = prog_elapsed[PAGE_W-1:0];
  assign arr_we        = commit_active && buf_hit;

  eeprom_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .we      (arr_we),
    .waddr   ({row_q, commit_idx}),
    .wdata   (buf_byte),
    .raddr   (ptr_q),
    .rdata_q (arr_q)
  );
endmodule

// File: rtl/eeprom_cmd_chk.sv
module eeprom_cmd_chk
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_start,
  input logic              bus_stop,
  input logic              wp,
  input logic              busy,
  input logic              wdat_valid,
  input logic              wdat_ready,
  input logic              rdat_valid,
  input logic              rdat_ready,
  input logic [DATA_W-1:0] rdat_data,
  input logic [ADDR_W-1:0] ptr_q,
  input ctl_state_e        state_q
);
  logic [31:0] busy_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1;
    else           busy_run_q <= '0;
  end

  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));

  assert_busy_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q == 32'(PROG_CYCLES)));

  assert_silent_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wdat_ready && !rdat_valid));

  assert_read_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat_valid && !rdat_ready && !bus_start && !bus_stop) |=> (rdat_valid && $stable(rdat_data)));

  assert_seq_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat_valid && rdat_ready) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

  assert_page_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_DATA && wdat_valid && wdat_ready) |=>
      ((ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])) &&
       (ptr_q[PAGE_W-1:0] == PAGE_W'($past(ptr_q[PAGE_W-1:0]) + 1'b1))));
endmodule

bind eeprom_cmd_ctrl eeprom_cmd_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_W      (PAGE_W),
  .DATA_W      (DATA_W),
  .PROG_CYCLES (PROG_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_start  (bus_start),
  .bus_stop   (bus_stop),
  .wp         (wp),
  .busy       (busy),
  .wdat_valid (wdat_valid),
  .wdat_ready (wdat_ready),
  .rdat_valid (rdat_valid),
  .rdat_ready (rdat_ready),
  .rdat_data  (rdat_data),
  .ptr_q      (ptr_q),
  .state_q    (state_q)
);

// File: tb/eeprom_cmd_ctrl_bench.sv
module eeprom_cmd_ctrl_bench;
  localparam int PROG = 40;

  typedef struct packed {
    logic [7:0] addr;
    logic [4:0] count;
    logic [7:0] seed;
    logic       prot;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{addr: 8'h20, count: 5'd1,  seed: 8'h11, prot: 1'b0},  // R2 single byte
    '{addr: 8'h35, count: 5'd4,  seed: 8'h40, prot: 1'b0},  // R5 partial page
    '{addr: 8'h7C, count: 5'd6,  seed: 8'h80, prot: 1'b0},  // R3 in-page wrap
    '{addr: 8'h90, count: 5'd20, seed: 8'hC0, prot: 1'b0},  // R4 overflow
    '{addr: 8'hA3, count: 5'd5,  seed: 8'h33, prot: 1'b1},  // R8 protected
    '{addr: 8'h00, count: 5'd16, seed: 8'hE0, prot: 1'b0}   // R5 full page
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0;
  logic       hdr_valid = 1'b0, hdr_read = 1'b0;
  logic       wp = 1'b0;
  logic       wdat_valid = 1'b0;
  logic       wdat_ready;
  logic [7:0] wdat_data = 8'h00;
  logic       rdat_valid;
  logic       rdat_ready = 1'b0;
  logic [7:0] rdat_data;
  logic       busy;

  int   n_checks = 0;
  int   n_fails  = 0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  eeprom_cmd_ctrl #(.PROG_CYCLES(PROG)) u_eeprom_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .hdr_valid(hdr_valid), .hdr_read(hdr_read), .wp(wp),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_data(rdat_data),
    .busy(busy)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    bus_start = 1'b1; tick(); bus_start = 1'b0;
  endtask

  task automatic do_stop();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
  endtask

  task automatic send_hdr(input logic rd);
    hdr_read = rd; hdr_valid = 1'b1; tick(); hdr_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    if (!wdat_ready) check("R13 wdat_ready", 0, 1);
    wdat_data = b; wdat_valid = 1'b1; tick(); wdat_valid = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int k = 0; k < 4 && !rdat_valid; k++) tick();
    b = rdat_data;
    rdat_ready = 1'b1; tick(); rdat_ready = 1'b0;
  endtask

  task automatic wait_idle(output int cycles);
    cycles = 0;
    while (busy && cycles < PROG + 20) begin
      cycles++; tick();
    end
  endtask

  // write transaction; model follows R3/R4/R5/R8
  task automatic write_seq(input logic [7:0] a, input int n, input logic [7:0] seed, input logic prot);
    logic [7:0] p;
    do_start(); send_hdr(1'b0); send_byte(a);
    p = a;
    for (int i = 0; i < n; i++) begin
      send_byte(seed + 8'(i));
      if (!prot) model[p] = seed + 8'(i);
      p = {p[7:4], p[3:0] + 4'd1};
    end
    wp = prot; do_stop(); wp = 1'b0;
  endtask

  task automatic rand_read(input string req, input logic [7:0] a, input int n);
    logic [7:0] b;
    do_start(); send_hdr(1'b0); send_byte(a);
    do_start(); send_hdr(1'b1);
    for (int i = 0; i < n; i++) begin
      read_byte(b);
      check(req, b, model[8'(a + 8'(i))]);
    end
    do_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [7:0] b;
    repeat (3) tick();
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 wdat_ready", wdat_ready, 0);
    check("R1 rdat_valid", rdat_valid, 0);
    rst_n = 1'b1; tick();

    // fill the array, page by page
    for (int pg = 0; pg < 16; pg++) begin
      write_seq(8'(pg * 16), 16, 8'(pg * 16) ^ 8'h5A, 1'b0);
      wait_idle(cyc);
      if (pg == 0) check("R10 busy length", cyc, PROG);
    end

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      write_seq(VECS[v].addr, int'(VECS[v].count), VECS[v].seed, VECS[v].prot);
      wait_idle(cyc);
      check("R5/R8 busy window", cyc, VECS[v].prot ? 0 : PROG);
      rand_read("R2/R3/R4/R5/R8 readback", {VECS[v].addr[7:4], 4'h0}, 16);
    end

    // R6: current read after top of array wraps to 0
    rand_read("R6 setup", 8'hFF, 1);
    do_start(); send_hdr(1'b1); read_byte(b); do_stop();
    check("R6 current read wrap", b, model[8'h00]);

    // R7: sequential read across the array end
    rand_read("R7 sequential wrap", 8'hFE, 4);

    // R12: pointer after a write that wrapped inside its page
    write_seq(8'h4E, 3, 8'h71, 1'b0); wait_idle(cyc);
    do_start(); send_hdr(1'b1); read_byte(b); do_stop();
    check("R12 pointer after write", b, model[8'h41]);

    // R9: dummy write then repeated start
    do_start(); send_hdr(1'b0); send_byte(8'h52);
    do_start(); send_hdr(1'b1); read_byte(b); do_stop();
    check("R9 random read", b, model[8'h52]);
    check("R9 no busy", busy, 0);
    do_start(); send_hdr(1'b0); send_byte(8'h60); send_byte(8'hEE);
    do_start(); send_hdr(1'b1); read_byte(b); do_stop();
    check("R9 read after discarded data", b, model[8'h61]);
    check("R9 discard no busy", busy, 0);
    rand_read("R9 location unchanged", 8'h60, 1);

    // R11: address-only write
    do_start(); send_hdr(1'b0); send_byte(8'h10); do_stop();
    check("R11 no busy", busy, 0);
    rand_read("R11 data unchanged", 8'h10, 1);

    // R10: headers ignored while busy
    write_seq(8'hB2, 2, 8'h21, 1'b0);
    check("R10 busy set", busy, 1);
    do_start(); send_hdr(1'b1); tick(); tick();
    check("R10 rdat_valid while busy", rdat_valid, 0);
    check("R10 wdat_ready while busy", wdat_ready, 0);
    do_stop();
    wait_idle(cyc);
    check("R10 busy clears", busy, 0);
    rand_read("R10 commit landed", 8'hB2, 2);

    // R13: read byte held while not taken
    do_start(); send_hdr(1'b0); send_byte(8'h20);
    do_start(); send_hdr(1'b1); tick();
    repeat (3) tick();
    check("R13 valid held", rdat_valid, 1);
    check("R13 data held", rdat_data, model[8'h20]);
    do_stop();

    // R1: reset mid-run resets pointer, keeps array
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    do_start(); send_hdr(1'b1); read_byte(b); do_stop();
    check("R1 pointer zero after reset", b, model[8'h00]);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule